// File: doc/BRIEF.md
# Pad Reset Qualifier and Stretcher

This block sits between a raw, active-low reset pin and the reset nets of a single clock domain. The pin level is first brought into the clock domain through a short flop chain. A run-length counter then decides whether the request is real: only a level held active for a programmable number of consecutive samples counts as a reset. Shorter noise is thrown away before it can touch any reset output.

A qualified request reloads a hold-down counter. Internal reset stays asserted until that counter has run out, however briefly the pin was held. The held level then passes through a retiming pipeline, so every synchronous consumer sees assertion and release on one shared clock edge. Release therefore comes several cycles after the pin goes inactive, and it is always aligned to the clock.

There are two outputs. `syncRst` is meant for general logic that resets synchronously. `asyncRst` is meant for the few flops that drive pads. It rises in the cycle the request qualifies, without waiting for the pipeline, and it falls on the same edge as `syncRst`. Both outputs are asserted from power-up until the first hold-down period has run out.

Top module: `resetConditioner`

## Requirements
- R1: From power-up, with the pin inactive, `syncRst` is 1 after each of the first STRETCH_CYCLES+1 rising edges and 0 after edge STRETCH_CYCLES+2. `asyncRst` is 1 for at least as long.
- R2: The pin is active when `padRstN` is 0. A request qualifies after edge n when the pin was sampled active on FILTER_CYCLES consecutive edges ending at edge n-2 (two synchronizer stages).
- R3: An active pulse covering fewer than FILTER_CYCLES sampling edges leaves both outputs at 0 once power-up reset has ended.
- R4: One inactive sample restarts the width count, so two sub-minimum pulses separated by a single inactive cycle do not qualify.
- R5: After a qualified request, `syncRst` stays 1 for at least STRETCH_CYCLES consecutive cycles, even if the pin is released at once.
- R6: `syncRst` after edge n equals the hold-down state after edge n-2 (two retiming stages). The hold-down state is active after edge j when a request was qualified after some edge in [j-STRETCH_CYCLES, j-1].
- R7: `asyncRst` is 1 after the edge where a request qualifies. It is also 1 whenever the hold-down state or any retiming stage is active, so it never drops while `syncRst` is still due to assert.
- R8: `asyncRst` never falls on an edge where `syncRst` does not also fall.
- R9: A pin held active for a long time keeps both outputs at 1 for as long as it stays qualified.
- R10: A new qualified request during a running hold-down period restarts the full STRETCH_CYCLES period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Domain clock |
| padRstN | input | 1 | Raw reset pin level, active low, asynchronous to clk |
| syncRst | output | 1 | Active-high reset for synchronous logic, aligned to clk |
| asyncRst | output | 1 | Active-high reset for pad-driving flops; early assertion, release aligned with syncRst |

## Verification
The hardest case to reach is a pulse exactly one sample short of, or exactly at, the qualifying width. The same goes for a second request that lands while the hold-down is still counting. Both depend on where the pin edges fall relative to the sampling edges. The stimulus therefore drives the pin only between clock edges, one cycle at a time. Directed pulses of width FILTER_CYCLES-1, FILTER_CYCLES and FILTER_CYCLES+1 are placed right after the power-up window and at short spacings. A long pseudo-random pin pattern follows, in which runs near the threshold appear often. Every cycle's outputs are predicted from a window-based model of the sampled pin history.

// File: rtl/rstCondPkg.sv
package rstCondPkg;

  // Strobes passed from the qualifying control to the hold/retime datapath.
  typedef struct packed {
    logic qualify;   // request is currently qualified (width reached)
  } rstStrobe_t;

endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain = '0;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk) chain <= din;
    end else begin : gMulti
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/rstCtrl.sv
module rstCtrl
  import rstCondPkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int FILTER_CYCLES = 4
) (
  input  logic       clk,
  input  logic       padRstN,
  output rstStrobe_t strobe
);

  localparam int CW = $clog2(FILTER_CYCLES + 1);
  localparam logic [CW-1:0] WIDTH_MAX = CW'(FILTER_CYCLES);

  logic padActive;
  logic sampledActive;
  logic [CW-1:0] widthCnt = '0;

  assign padActive = ~padRstN;

  syncChain #(.STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .din (padActive),
    .dout(sampledActive)
  );

  // Run-length counter: saturates at the minimum width, clears on any gap.
  always_ff @(posedge clk) begin
    if (!sampledActive)
      widthCnt <= '0;
    else if (widthCnt != WIDTH_MAX)
      widthCnt <= widthCnt + 1'b1;
  end

  always_comb begin
    strobe.qualify = (widthCnt == WIDTH_MAX);
  end

endmodule

// File: rtl/rstDatapath.sv
module rstDatapath
  import rstCondPkg::*;
#(
  parameter int STRETCH_CYCLES = 8,
  parameter int RETIME_STAGES  = 2
) (
  input  logic       clk,
  input  rstStrobe_t strobe,
  output logic       syncRst,
  output logic       asyncRst
);

  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [SW-1:0] HOLD_MAX = SW'(STRETCH_CYCLES);

  logic [SW-1:0] holdCnt = HOLD_MAX;
  logic          heldRst;
  logic [RETIME_STAGES-1:0] retimePipe = '1;

  // Hold-down counter: any qualified cycle reloads the full period.
  always_ff @(posedge clk) begin
    if (strobe.qualify)
      holdCnt <= HOLD_MAX;
    else if (holdCnt != '0)
      holdCnt <= holdCnt - 1'b1;
  end

  assign heldRst = (holdCnt != '0);

  generate
    if (RETIME_STAGES == 1) begin : gRetimeOne
      always_ff @(posedge clk) retimePipe <= heldRst;
    end else begin : gRetimeMany
      always_ff @(posedge clk)
        retimePipe <= {retimePipe[RETIME_STAGES-2:0], heldRst};
    end
  endgenerate

  assign syncRst  = retimePipe[RETIME_STAGES-1];
  assign asyncRst = strobe.qualify | heldRst | (|retimePipe);

endmodule

// File: rtl/resetConditioner.sv
module resetConditioner
  import rstCondPkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int FILTER_CYCLES  = 4,
  parameter int STRETCH_CYCLES = 8,
  parameter int RETIME_STAGES  = 2
) (
  input  logic clk,
  input  logic padRstN,
  output logic syncRst,
  output logic asyncRst
);

  rstStrobe_t strobe;

  rstCtrl #(
    .SYNC_STAGES  (SYNC_STAGES),
    .FILTER_CYCLES(FILTER_CYCLES)
  ) uCtrl (
    .clk    (clk),
    .padRstN(padRstN),
    .strobe (strobe)
  );

  rstDatapath #(
    .STRETCH_CYCLES(STRETCH_CYCLES),
    .RETIME_STAGES (RETIME_STAGES)
  ) uPath (
    .clk     (clk),
    .strobe  (strobe),
    .syncRst (syncRst),
    .asyncRst(asyncRst)
  );

endmodule

// File: rtl/resetConditionerChecker.sv
module resetConditionerChecker #(
  parameter int FILTER_CYCLES  = 4,
  parameter int STRETCH_CYCLES = 8
) (
  input logic clk,
  input logic padRstN,
  input logic syncRst,
  input logic asyncRst
);

  localparam int RW = $clog2(FILTER_CYCLES + 2) + 1;
  localparam int HW = $clog2(STRETCH_CYCLES + 2) + 1;
  localparam logic [RW-1:0] RUN_SAT  = RW'(FILTER_CYCLES);
  localparam logic [HW-1:0] HOLD_SAT = HW'(STRETCH_CYCLES);

  logic [1:0]    warm    = '0;
  logic [RW-1:0] padRun  = '0;
  logic [HW-1:0] holdRun = '0;
  logic          ready;

  always_ff @(posedge clk) begin
    if (warm != 2'd3) warm <= warm + 2'd1;
    if (padRstN) padRun <= '0;
    else if (padRun != RUN_SAT) padRun <= padRun + 1'b1;
    if (!syncRst) holdRun <= '0;
    else if (holdRun != HOLD_SAT) holdRun <= holdRun + 1'b1;
  end

  assign ready = (warm == 2'd3);

  // R7: the pad-side reset covers the synchronous one.
  assert_async_covers_sync_R7: assert property (@(posedge clk) disable iff (!ready)
    syncRst |-> asyncRst);

  // R7: once the pad-side reset is up ahead of syncRst, it stays up.
  assert_async_stays_R7: assert property (@(posedge clk) disable iff (!ready)
    (asyncRst && !syncRst) |=> asyncRst);

  // R8: the pad-side reset only releases together with syncRst.
  assert_joint_release_R8: assert property (@(posedge clk) disable iff (!ready)
    $fell(asyncRst) |-> $fell(syncRst));

  // R3: a new assertion needs a pin run of at least the minimum width.
  assert_no_short_qualify_R3: assert property (@(posedge clk) disable iff (!ready)
    $rose(asyncRst) |-> ($past(padRun, 2) >= RUN_SAT));

  // R5: every syncRst assertion lasts at least the stretch period.
  assert_min_hold_R5: assert property (@(posedge clk) disable iff (!ready)
    $fell(syncRst) |-> (holdRun >= HOLD_SAT));

endmodule

bind resetConditioner resetConditionerChecker #(
  .FILTER_CYCLES (FILTER_CYCLES),
  .STRETCH_CYCLES(STRETCH_CYCLES)
) uChecker (
  .clk     (clk),
  .padRstN (padRstN),
  .syncRst (syncRst),
  .asyncRst(asyncRst)
);

// File: tb/resetConditioner_test.sv
module resetConditioner_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int F    = 4;
  localparam int S    = 8;
  localparam int MAXE = 4096;

  logic clk = 1'b0;
  logic padRstN = 1'b1;
  logic syncRst;
  logic asyncRst;

  int total = 0;
  int bad   = 0;
  int edgeN = 0;
  bit done  = 0;
  bit act [0:MAXE-1];

  resetConditioner #(
    .SYNC_STAGES(2), .FILTER_CYCLES(F), .STRETCH_CYCLES(S), .RETIME_STAGES(2)
  ) uut (
    .clk(clk), .padRstN(padRstN), .syncRst(syncRst), .asyncRst(asyncRst)
  );

  always #10 clk = ~clk;   // 50 MHz
  always @(posedge clk) edgeN <= edgeN + 1;

  // Request qualified after edge n: F active samples ending at edge n-2 (R2).
  function automatic bit fvAt(int n);
    int run = 0;
    if (n < 3) return 0;
    for (int k = n - 2; k >= 1 && act[k] && run < F; k--) run++;
    return run >= F;
  endfunction

  // Hold-down active after edge j (power-up window or recent request).
  function automatic bit heldAt(int j);
    if (j < S) return 1;
    for (int m = j - S; m <= j - 1; m++) if (fvAt(m)) return 1;
    return 0;
  endfunction

  task automatic check(string tag);
    bit expS, expA;
    int n = edgeN;
    expS = heldAt(n - 2);
    expA = fvAt(n) || heldAt(n) || heldAt(n - 1) || heldAt(n - 2);
    total++;
    if (syncRst !== expS) begin
      bad++;
      $display("FAIL %s syncRst edge %0d: actual=%0b expected=%0b", tag, n, syncRst, expS);
    end
    total++;
    if (asyncRst !== expA) begin
      bad++;
      $display("FAIL R7 (%s) asyncRst edge %0d: actual=%0b expected=%0b", tag, n, asyncRst, expA);
    end
  endtask

  task automatic step(bit active, string tag);
    @(negedge clk);
    check(tag);
    act[edgeN + 1] = active;
    padRstN = ~active;
  endtask

  task automatic pulse(int width, int gap, string tag);
    for (int i = 0; i < width; i++) step(1'b1, tag);
    for (int i = 0; i < gap; i++) step(1'b0, tag);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < MAXE; i++) act[i] = 0;
    // R1: power-up window with the pin idle
    for (int i = 0; i < 20; i++) step(1'b0, "R1");
    // R3: sub-minimum pulses
    pulse(1, 6, "R3");
    pulse(2, 6, "R3");
    pulse(F - 1, 20, "R3");
    // R4: gap of one sample restarts the width count
    pulse(F - 1, 1, "R4");
    pulse(F - 1, 20, "R4");
    // R2: exactly the minimum width qualifies
    pulse(F, 30, "R2");
    // R5: stretch period after a short valid request
    pulse(F + 1, 30, "R5");
    // R6: retiming latency on assertion and release
    pulse(F + 2, 30, "R6");
    // R9: long assertion
    pulse(40, 30, "R9");
    // R10: re-qualify during running hold-down
    pulse(F, 5, "R10");
    pulse(F + 2, 30, "R10");
    // R8: pseudo-random pin activity, release alignment throughout
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], "R8");
    end
    for (int i = 0; i < 30; i++) step(1'b0, "R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule